// File: doc/BRIEF.md
# Open-drain error and event pin controller

This block sits between internal logic and two groups of shared, active-low, wired-OR pins. One group is a 3-bit error code and the other is a 4-bit event group. A pin is driven by pulling it low. Each pin therefore has a drive-enable output to the pad and a raw input sampled back from the pad. A one-cycle drive request from internal logic becomes a drive of guaranteed minimum length. The block also notices when other agents on the wire pull a pin low.

On the input side, every raw pin may change at any moment relative to the core clock. Each pin passes through a two-stage synchroniser and then a stability filter. The filter only moves its output once the synchronised value has held a new level for a set number of samples. The filtered error code feeds a first-error capture register. That register records only errors raised by other agents. It stops sampling in the cycle before the block starts driving, and it stays blind until its own drive has cleared out of the filter. Software empties it with a clear strobe.

Top module: `odpin_err_evt`

## Requirements
- R1: After reset, all drive enables are 0, all filtered outputs are 1 (idle), `cap_valid_o` is 0 and `cap_code_o` is 0.
- R2: A drive request on an error bit sets its drive enable from the next cycle, for exactly 12 cycles.
- R3: A new request on a bit that is already being driven restarts the count, so the drive lasts 12 cycles after the last request.
- R4: A filtered output follows a raw pin level held steady, with a latency of 6 clock edges: 2 synchroniser stages plus 4 equal samples. The filtered output never changes on two consecutive cycles.
- R5: A raw pin pulse shorter than 4 synchronised samples (3 cycles) leaves the filtered output unchanged. A 4-cycle pulse is accepted.
- R6: The event pins use the same 12-cycle drive and the same filter. Each bit is independent, and a request on one pin drives no other pin.
- R7: `cap_code_o` holds error bits, with 1 meaning asserted: bit 0 is correctable, bit 1 is non-correctable and bit 2 is fatal. The first non-idle filtered error code is latched one edge after it appears. The flag is `cap_valid_o=1`. Later changes do not alter the latched code.
- R8: A `cap_clr_i` pulse empties the register (valid 0, code 0) at the next edge. This takes priority over a capture in the same cycle. An error still present is recaptured one edge later.
- R9: Capture is blocked in the cycle where any error drive request is present, while any error drive is active, and for 6 cycles after the last error drive ends. The block's own drive is therefore never recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_req_i | input | 3 | Per-bit error drive requests, active high |
| evt_req_i | input | 4 | Per-bit event drive requests, active high |
| err_pin_i | input | 3 | Raw error pin levels, active low, asynchronous |
| evt_pin_i | input | 4 | Raw event pin levels, active low, asynchronous |
| cap_clr_i | input | 1 | Clear strobe for the capture register |
| err_drv_o | output | 3 | Error pin pull-down enables |
| evt_drv_o | output | 4 | Event pin pull-down enables |
| err_filt_o | output | 3 | Filtered error levels, active low |
| evt_filt_o | output | 4 | Filtered event levels, active low |
| cap_valid_o | output | 1 | Capture register holds an error |
| cap_code_o | output | 3 | Captured error bits, 1 = asserted |

## Verification
- **Stretch counter:** A wrong counter state appears on the drive enable within one cycle, either as a drive that is too short, too long or restarted wrongly, and is measured edge by edge.
- **Filter state:** A wrong filter state shows as a filtered output that moves one edge early or late, or that follows a rejected glitch. Every transition is sampled on the exact edge it is due.
- **Capture gate:** A wrong gate or blanking state makes the capture register record the block's own drive, or miss a foreign error. This becomes visible within 7 edges of the pin change.

// File: rtl/odpin_pkg.sv
package odpin_pkg;
  localparam int unsigned ERR_BITS = 3;
  localparam int unsigned EVT_BITS = 4;

  typedef enum logic [1:0] {
    ERR_CORR   = 2'd0,
    ERR_UNCORR = 2'd1,
    ERR_FATAL  = 2'd2
  } err_idx_e;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/odpin_stretch.sv
module odpin_stretch #(
  parameter int unsigned W    = 3,
  parameter int unsigned HOLD = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] req_i,
  output logic [W-1:0] drv_o
);
  localparam int unsigned CW = odpin_pkg::cnt_w(HOLD);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [CW-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             cnt_q <= '0;
      else if (req_i[g])       cnt_q <= CW'(HOLD);  // restart on every request
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end
    assign drv_o[g] = (cnt_q != '0);
  end
endmodule

// File: rtl/odpin_filter.sv
module odpin_filter #(
  parameter int unsigned W      = 3,
  parameter int unsigned SYNC   = 2,
  parameter int unsigned STABLE = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] filt_o
);
  localparam int unsigned CW = odpin_pkg::cnt_w(STABLE);

  logic [W-1:0] sync_q [SYNC];
  logic [W-1:0] synced;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SYNC; s++) sync_q[s] <= '1;
    end else begin
      sync_q[0] <= pin_i;
      for (int s = 1; s < SYNC; s++) sync_q[s] <= sync_q[s-1];
    end
  end
  assign synced = sync_q[SYNC-1];

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [CW-1:0] cnt_q;
    logic          filt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q  <= '0;
        filt_q <= 1'b1;
      end else if (synced[g] != filt_q) begin
        if (cnt_q == CW'(STABLE - 1)) begin
          filt_q <= synced[g];
          cnt_q  <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
    assign filt_o[g] = filt_q;
  end
endmodule

// File: rtl/odpin_capture.sv
module odpin_capture #(
  parameter int unsigned W     = 3,
  parameter int unsigned BLANK = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         own_req_i,
  input  logic         own_drv_i,
  input  logic [W-1:0] filt_n_i,
  input  logic         clr_i,
  output logic         valid_o,
  output logic [W-1:0] code_o
);
  localparam int unsigned BW = odpin_pkg::cnt_w(BLANK);

  logic [BW-1:0] tail_q;
  logic          open;
  logic [W-1:0]  seen;

  // hold off while our own pull-down is still in the filter pipeline
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tail_q <= '0;
    else if (own_drv_i)       tail_q <= BW'(BLANK);
    else if (tail_q != '0)    tail_q <= tail_q - 1'b1;
  end

  assign open = !own_req_i && !own_drv_i && (tail_q == '0);
  assign seen = ~filt_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else if (clr_i) begin
      valid_o <= 1'b0;
      code_o  <= '0;
    end else if (!valid_o && open && (seen != '0)) begin
      valid_o <= 1'b1;
      code_o  <= seen;
    end
  end
endmodule

// File: rtl/odpin_err_evt.sv
module odpin_err_evt #(
  parameter int unsigned ERR_W  = odpin_pkg::ERR_BITS,
  parameter int unsigned EVT_W  = odpin_pkg::EVT_BITS,
  parameter int unsigned HOLD   = 12,
  parameter int unsigned SYNC   = 2,
  parameter int unsigned STABLE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ERR_W-1:0] err_req_i,
  input  logic [EVT_W-1:0] evt_req_i,
  input  logic [ERR_W-1:0] err_pin_i,
  input  logic [EVT_W-1:0] evt_pin_i,
  input  logic             cap_clr_i,
  output logic [ERR_W-1:0] err_drv_o,
  output logic [EVT_W-1:0] evt_drv_o,
  output logic [ERR_W-1:0] err_filt_o,
  output logic [EVT_W-1:0] evt_filt_o,
  output logic             cap_valid_o,
  output logic [ERR_W-1:0] cap_code_o
);
  localparam int unsigned BLANK = SYNC + STABLE;

  odpin_stretch #(.W(ERR_W), .HOLD(HOLD)) i_err_stretch (
    .clk_i, .rst_ni, .req_i(err_req_i), .drv_o(err_drv_o)
  );
  odpin_stretch #(.W(EVT_W), .HOLD(HOLD)) i_evt_stretch (
    .clk_i, .rst_ni, .req_i(evt_req_i), .drv_o(evt_drv_o)
  );

  odpin_filter #(.W(ERR_W), .SYNC(SYNC), .STABLE(STABLE)) i_err_filt (
    .clk_i, .rst_ni, .pin_i(err_pin_i), .filt_o(err_filt_o)
  );
  odpin_filter #(.W(EVT_W), .SYNC(SYNC), .STABLE(STABLE)) i_evt_filt (
    .clk_i, .rst_ni, .pin_i(evt_pin_i), .filt_o(evt_filt_o)
  );

  odpin_capture #(.W(ERR_W), .BLANK(BLANK)) i_capture (
    .clk_i,
    .rst_ni,
    .own_req_i(|err_req_i),
    .own_drv_i(|err_drv_o),
    .filt_n_i (err_filt_o),
    .clr_i    (cap_clr_i),
    .valid_o  (cap_valid_o),
    .code_o   (cap_code_o)
  );
endmodule

// File: rtl/odpin_err_evt_chk.sv
module odpin_err_evt_chk #(
  parameter int unsigned ERR_W = 3,
  parameter int unsigned EVT_W = 4,
  parameter int unsigned HOLD  = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ERR_W-1:0] err_req_i,
  input logic [EVT_W-1:0] evt_req_i,
  input logic             cap_clr_i,
  input logic [ERR_W-1:0] err_drv_o,
  input logic [EVT_W-1:0] evt_drv_o,
  input logic [ERR_W-1:0] err_filt_o,
  input logic [EVT_W-1:0] evt_filt_o,
  input logic             cap_valid_o,
  input logic [ERR_W-1:0] cap_code_o
);
  localparam int unsigned AW = odpin_pkg::cnt_w(HOLD);

  for (genvar i = 0; i < ERR_W; i++) begin : g_err
    logic [AW-1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 age_q <= '0;
      else if (err_req_i[i])                       age_q <= AW'(1);
      else if (age_q != '0 && age_q < AW'(HOLD))   age_q <= age_q + 1'b1;
      else                                         age_q <= '0;
    end
    a_r2_drive_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_drv_o[i] == (age_q != '0));
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_evt
    logic [AW-1:0] age_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 age_q <= '0;
      else if (evt_req_i[i])                       age_q <= AW'(1);
      else if (age_q != '0 && age_q < AW'(HOLD))   age_q <= age_q + 1'b1;
      else                                         age_q <= '0;
    end
    a_r6_evt_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_drv_o[i] == (age_q != '0));
  end

  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_req_i != '0) |=> ((err_drv_o & $past(err_req_i)) == $past(err_req_i)));

  a_r4_err_no_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(err_filt_o) |=> $stable(err_filt_o));

  a_r4_evt_no_double: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(evt_filt_o) |=> $stable(evt_filt_o));

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid_o && !cap_clr_i) |=> (cap_valid_o && $stable(cap_code_o)));

  a_r7_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_valid_o) |-> (cap_code_o != '0));

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_clr_i |=> (!cap_valid_o && cap_code_o == '0));

  a_r9_no_capture_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((err_req_i != '0) || (err_drv_o != '0)) |=> !$rose(cap_valid_o));
endmodule

bind odpin_err_evt odpin_err_evt_chk #(
  .ERR_W(ERR_W), .EVT_W(EVT_W), .HOLD(HOLD)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .err_req_i  (err_req_i),
  .evt_req_i  (evt_req_i),
  .cap_clr_i  (cap_clr_i),
  .err_drv_o  (err_drv_o),
  .evt_drv_o  (evt_drv_o),
  .err_filt_o (err_filt_o),
  .evt_filt_o (evt_filt_o),
  .cap_valid_o(cap_valid_o),
  .cap_code_o (cap_code_o)
);

// File: tb/test_odpin_err_evt.sv
module test_odpin_err_evt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] err_req = '0;
  logic [3:0] evt_req = '0;
  logic [2:0] err_ext = '0;
  logic [3:0] evt_ext = '0;
  logic       cap_clr = 1'b0;
  logic [2:0] err_drv, err_filt, cap_code;
  logic [3:0] evt_drv, evt_filt;
  logic       cap_valid;
  logic [2:0] err_pin;
  logic [3:0] evt_pin;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  // wired-OR pin model: low if we or another agent pull down
  assign err_pin = ~(err_drv | err_ext);
  assign evt_pin = ~(evt_drv | evt_ext);

  odpin_err_evt i_odpin_err_evt (
    .clk_i(clk), .rst_ni(rst_n),
    .err_req_i(err_req), .evt_req_i(evt_req),
    .err_pin_i(err_pin), .evt_pin_i(evt_pin),
    .cap_clr_i(cap_clr),
    .err_drv_o(err_drv), .evt_drv_o(evt_drv),
    .err_filt_o(err_filt), .evt_filt_o(evt_filt),
    .cap_valid_o(cap_valid), .cap_code_o(cap_code)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_cap();
    @(negedge clk) cap_clr = 1'b1;
    @(negedge clk) cap_clr = 1'b0;
  endtask

  task automatic t_r1_reset();
    check(err_drv == 3'b000, "R1 err_drv", err_drv, 0);
    check(evt_drv == 4'b0000, "R1 evt_drv", evt_drv, 0);
    check(err_filt == 3'b111 && evt_filt == 4'b1111, "R1 filt idle", {evt_filt, err_filt}, 127);
    check(!cap_valid && cap_code == 3'b000, "R1 capture empty", {cap_valid, cap_code}, 0);
  endtask

  task automatic t_r2_stretch();
    int n = 0;
    @(negedge clk) err_req = 3'b001;
    @(negedge clk) err_req = 3'b000;
    check(err_drv[0], "R2 drive starts next cycle", err_drv[0], 1);
    repeat (20) begin
      if (err_drv[0]) n++;
      @(negedge clk);
    end
    check(n == 12, "R2 drive length", n, 12);
    wait_neg(10);
  endtask

  task automatic t_r3_restart();
    int n = 0;
    @(negedge clk) err_req = 3'b010;
    @(negedge clk) err_req = 3'b000;
    wait_neg(4);
    check(err_drv[1], "R3 still driving before retrigger", err_drv[1], 1);
    err_req = 3'b010;
    @(negedge clk) err_req = 3'b000;
    repeat (20) begin
      if (err_drv[1]) n++;
      @(negedge clk);
    end
    check(n == 12, "R3 length after retrigger", n, 12);
    wait_neg(10);
  endtask

  task automatic t_r6_event();
    int n = 0;
    int other = 0;
    @(negedge clk) evt_req = 4'b1000;
    @(negedge clk) evt_req = 4'b0000;
    repeat (20) begin
      if (evt_drv[3]) n++;
      if (evt_drv[2:0] != 3'b000 || err_drv != 3'b000) other++;
      @(negedge clk);
    end
    check(n == 12, "R6 event drive length", n, 12);
    check(other == 0, "R6 no cross drive", other, 0);
    wait_neg(10);
  endtask

  task automatic t_r4_latency();
    @(negedge clk) evt_ext = 4'b0010;
    wait_neg(5);
    check(evt_filt[1], "R4 not yet at edge 5", evt_filt[1], 1);
    @(negedge clk);
    check(!evt_filt[1], "R4 low at edge 6", evt_filt[1], 0);
    check(evt_filt[3:2] == 2'b11 && evt_filt[0], "R6 other event bits idle", evt_filt, 13);
    evt_ext = 4'b0000;
    wait_neg(5);
    check(!evt_filt[1], "R4 still low at edge 5", evt_filt[1], 0);
    @(negedge clk);
    check(evt_filt[1], "R4 high at edge 6", evt_filt[1], 1);
    wait_neg(4);
  endtask

  task automatic t_r5_glitch();
    int lows = 0;
    @(negedge clk) err_ext = 3'b001;
    wait_neg(3);
    err_ext = 3'b000;
    repeat (12) begin
      if (!err_filt[0]) lows++;
      @(negedge clk);
    end
    check(lows == 0, "R5 short pulse rejected", lows, 0);
    check(!cap_valid, "R5 no capture from glitch", cap_valid, 0);
    lows = 0;
    err_ext = 3'b001;
    wait_neg(4);
    err_ext = 3'b000;
    repeat (12) begin
      if (!err_filt[0]) lows++;
      @(negedge clk);
    end
    check(lows == 4, "R5 4-cycle pulse accepted", lows, 4);
    clear_cap();
    wait_neg(2);
  endtask

  task automatic t_r7_first();
    clear_cap();
    @(negedge clk) err_ext = 3'b100;
    wait_neg(6);
    check(!cap_valid, "R7 not yet captured at edge 6", cap_valid, 0);
    @(negedge clk);
    check(cap_valid && cap_code == 3'b100, "R7 fatal captured", {cap_valid, cap_code}, 12);
    err_ext = 3'b101;
    wait_neg(10);
    check(cap_code == 3'b100, "R7 later error ignored", cap_code, 4);
    err_ext = 3'b000;
    wait_neg(10);
    check(cap_valid && cap_code == 3'b100, "R7 held after release", {cap_valid, cap_code}, 12);
    clear_cap();
    @(negedge clk) err_ext = 3'b011;
    wait_neg(7);
    check(cap_code == 3'b011, "R7 two bits together", cap_code, 3);
  endtask

  task automatic t_r8_clear();
    @(negedge clk) cap_clr = 1'b1;
    @(negedge clk) cap_clr = 1'b0;
    check(!cap_valid && cap_code == 3'b000, "R8 cleared", {cap_valid, cap_code}, 0);
    @(negedge clk);
    check(cap_valid && cap_code == 3'b011, "R8 recapture of live error", {cap_valid, cap_code}, 11);
    err_ext = 3'b000;
    wait_neg(10);
    clear_cap();
    check(!cap_valid, "R8 clear after release", cap_valid, 0);
  endtask

  task automatic t_r9_own_drive();
    int lows = 0;
    @(negedge clk) err_req = 3'b010;
    @(negedge clk) err_req = 3'b000;
    repeat (30) begin
      if (!err_filt[1]) lows++;
      @(negedge clk);
    end
    check(lows == 12, "R9 own drive seen on filter", lows, 12);
    check(!cap_valid, "R9 own drive not captured", cap_valid, 0);
    err_ext = 3'b001;
    wait_neg(7);
    check(cap_valid && cap_code == 3'b001, "R9 foreign error captured after", {cap_valid, cap_code}, 9);
    err_ext = 3'b000;
    wait_neg(10);
  endtask

  initial begin
    #1_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_neg(3);
    t_r1_reset();
    rst_n = 1'b1;
    wait_neg(2);
    t_r1_reset();
    t_r2_stretch();
    t_r3_restart();
    t_r6_event();
    t_r4_latency();
    t_r5_glitch();
    t_r7_first();
    t_r8_clear();
    t_r9_own_drive();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule